// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a configuration image into a downstream FPGA through that device's serial slave configuration port. After a one-cycle start pulse it pulls the target's open-drain reset low while also holding the slave-select low. It then releases the reset and waits for the target to clear its configuration memory. It checks that the target's done flag is still low and sends one byte of zero-data clocks with the select high. Next it lowers the select and streams the whole image, most significant bit first, with no gap between bytes. Finally it raises the select, sends trailing zero clocks, checks that done has gone high, and sends a second group of zero clocks so that the target's user I/O starts working.

Image bytes are read one at a time through a request/valid port. The next byte is fetched while the current one is still shifting, so the serial stream does not pause. The serial clock follows SPI mode 3: it idles high, the target samples on the rising edge, and data changes only on the falling edge. All timing comes from cycle-count parameters on the system clock. At the defaults on a 200 MHz clock the reset pulse is 200 ns, the clear wait is 1.2 ms and the serial clock is 12.5 MHz. The block reports busy, a success flag, a failure flag and an error code that says which check failed.

Top module: `cfgSeqTop`

## Requirements
- R1: After reset the block is idle: `busy`, `success`, `failure` and `rdReq` are 0, `cfgSelN` is 1, `cfgSck` is 1 and `cfgRstPull` is 0 (target reset released).
- R2: A `start` pulse while idle makes `cfgRstPull` go to 1 for RST_CYCLES clock cycles, with `cfgSelN` held at 0 throughout. No serial clock edge occurs during this time.
- R3: After the reset is released, `cfgSelN` stays 0 and `cfgSck` stays high for at least CLEAR_CYCLES cycles. Then `cfgDone` is checked. If it is high, the run ends with `failure`=1, `errKind`=1 and no serial clock edges.
- R4: If `cfgDone` was low at that check, the block raises `cfgSelN` and sends exactly 8 serial clocks with `cfgMosi` at 0 on every rising edge.
- R5: The block then lowers `cfgSelN` and sends image bytes for addresses 0 to IMAGE_BYTES-1 in order, most significant bit first. Consecutive rising edges are exactly 2*HALF_DIV cycles apart across the whole image, including between bytes.
- R6: `cfgSck` idles high. Each half period lasts HALF_DIV cycles. `cfgMosi` changes only in the cycle in which `cfgSck` falls, and `cfgSelN` changes only while `cfgSck` is high.
- R7: After the last image byte the block raises `cfgSelN` and sends POST_BYTES*8 zero clocks (104 by default). It then checks `cfgDone`. If `cfgDone` is low, the run ends with `failure`=1 and `errKind`=2.
- R8: If `cfgDone` is high at that check, the block sends ACT_BYTES*8 more zero clocks (104 by default) with `cfgSelN` high and then ends with `success`=1 and `errKind`=0. `success` and `failure` are never both 1.
- R9: If the next image byte has not arrived by the end of the current byte, the serial clock stops high and no further bit is sent. The run ends with `failure`=1 and `errKind`=3.
- R10: A `start` pulse while `busy` is 1 is ignored. The target reset is not pulled again and the running sequence finishes unchanged.
- R11: When a run ends, `busy` drops to 0, the lines return to their idle levels (`cfgSelN`=1, `cfgSck`=1, `cfgRstPull`=0, `rdReq`=0), and `success`, `failure` and `errKind` hold their values until the next accepted start.
- R12: Once `rdReq` is raised, it stays 1 with `rdAddr` unchanged until a cycle in which `rdValid` is 1, unless the run ends first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts a configuration run |
| busy | output | 1 | High while a run is in progress |
| success | output | 1 | The last run finished with the target configured |
| failure | output | 1 | The last run was aborted |
| errKind | output | 2 | 0 none, 1 done high after clear, 2 done low after image, 3 image byte underrun |
| cfgRstPull | output | 1 | Open-drain enable; 1 pulls the target reset low |
| cfgSelN | output | 1 | Active-low slave-select to the target |
| cfgSck | output | 1 | Serial clock (mode 3) |
| cfgMosi | output | 1 | Serial data to the target |
| cfgDone | input | 1 | Target done flag (pulled up) |
| rdReq | output | 1 | Image byte request |
| rdAddr | output | ADDR_W | Image byte address |
| rdValid | input | 1 | Image byte valid; completes the request |
| rdData | input | 8 | Image byte |

## Verification
A sequencer stuck in the wrong phase shows at the ports as a wrong select level for that phase, or as a wrong number of clocks inside a select window. The bench counts rising edges per window, so this shows up by the end of the affected window, at most one image length later. A damaged shift path or lost byte fetch produces a wrong byte within eight serial clocks, or a rise-to-rise spacing other than 2*HALF_DIV at the next byte boundary. A wrong done decision appears as the wrong error code, or as 104 missing or extra clocks as soon as the run ends.

// File: rtl/cfgSeqPkg.sv
package cfgSeqPkg;

  localparam int BYTE_W = 8;

  // strobes from sequencer to serial datapath
  typedef struct packed {
    logic avail;     // a byte may be consumed at the next slot
    logic zeroFill;  // consume a zero byte instead of the image byte
  } dpCmd_t;

  typedef enum logic [1:0] {
    ERR_NONE       = 2'd0,
    ERR_EARLY_DONE = 2'd1,
    ERR_NO_DONE    = 2'd2,
    ERR_UNDERRUN   = 2'd3
  } errKind_t;

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_CLEAR, S_CHK0, S_PRE, S_IMG, S_POST, S_CHK1, S_ACT
  } seqState_t;

endpackage

// File: rtl/cfgSerDp.sv
module cfgSerDp
  import cfgSeqPkg::*;
#(
  parameter int HALF_DIV = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [BYTE_W-1:0] nextByte,
  output logic              take,
  output logic              busy,
  output logic              sck,
  output logic              mosi
);

  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
  localparam int BIT_W = $clog2(BYTE_W);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitIdx;
  logic [BYTE_W-1:0] shReg;
  logic              cntDone;
  logic              byteEnd;
  logic [BYTE_W-1:0] loadVal;

  assign cntDone = (cnt == CNT_LAST);
  assign byteEnd = (phase == PH_HIGH) && cntDone && (bitIdx == '0);
  assign take    = cmd.avail && ((phase == PH_IDLE) || byteEnd);
  assign busy    = (phase != PH_IDLE);
  assign loadVal = cmd.zeroFill ? '0 : nextByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      shReg  <= '0;
      sck    <= 1'b1;
      mosi   <= 1'b0;
    end else if (take) begin
      // falling edge that puts the first bit of a fresh byte on the line
      shReg  <= loadVal;
      mosi   <= loadVal[BYTE_W-1];
      sck    <= 1'b0;
      phase  <= PH_LOW;
      cnt    <= '0;
      bitIdx <= BIT_W'(BYTE_W - 1);
    end else begin
      unique case (phase)
        PH_LOW: begin
          if (cntDone) begin
            sck   <= 1'b1;
            phase <= PH_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (cntDone) begin
            cnt <= '0;
            if (bitIdx != '0) begin
              bitIdx <= bitIdx - 1'b1;
              shReg  <= {shReg[BYTE_W-2:0], 1'b0};
              mosi   <= shReg[BYTE_W-2];
              sck    <= 1'b0;
              phase  <= PH_LOW;
            end else begin
              phase <= PH_IDLE;  // no byte ready: clock parks high
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: cnt <= '0;
      endcase
    end
  end

endmodule

// File: rtl/cfgSeqCtl.sv
module cfgSeqCtl
  import cfgSeqPkg::*;
#(
  parameter int RST_CYCLES   = 40,
  parameter int CLEAR_CYCLES = 240000,
  parameter int IMAGE_BYTES  = 135100,
  parameter int ADDR_W       = 18,
  parameter int PRE_BYTES    = 1,
  parameter int POST_BYTES   = 13,
  parameter int ACT_BYTES    = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              doneIn,
  input  logic              dpTake,
  input  logic              dpBusy,
  input  logic              rdValid,
  input  logic [BYTE_W-1:0] rdData,
  output dpCmd_t            dpCmd,
  output logic [BYTE_W-1:0] dpByte,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              busy,
  output logic              success,
  output logic              failure,
  output errKind_t          errKind,
  output logic              selN,
  output logic              rstPull
);

  localparam int TMR_MAX = (RST_CYCLES > CLEAR_CYCLES) ? RST_CYCLES : CLEAR_CYCLES;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int CNT_W   = $clog2(IMAGE_BYTES + 1);
  localparam int DUM_MAX = (POST_BYTES > ACT_BYTES) ?
                           ((POST_BYTES > PRE_BYTES) ? POST_BYTES : PRE_BYTES) :
                           ((ACT_BYTES > PRE_BYTES) ? ACT_BYTES : PRE_BYTES);
  localparam int DUM_W   = $clog2(DUM_MAX + 1);
  localparam logic [CNT_W-1:0] IMG_N = CNT_W'(IMAGE_BYTES);

  seqState_t         state;
  logic [TMR_W-1:0]  tmr;
  logic [CNT_W-1:0]  fetchCnt;
  logic [CNT_W-1:0]  sentCnt;
  logic [DUM_W-1:0]  dumLeft;
  logic [BYTE_W-1:0] bufData;
  logic              bufFull;
  logic              doneMeta;
  logic              doneSync;
  logic              fetching;

  always_comb begin
    dpCmd.avail    = 1'b0;
    dpCmd.zeroFill = 1'b1;
    unique case (state)
      S_PRE, S_POST, S_ACT: dpCmd.avail = (dumLeft != '0);
      S_IMG: begin
        dpCmd.zeroFill = 1'b0;
        // after the first byte, only a running shifter may take more
        dpCmd.avail = bufFull && ((sentCnt == '0) || dpBusy);
      end
      default: dpCmd.avail = 1'b0;
    endcase
  end

  assign dpByte   = bufData;
  assign busy     = (state != S_IDLE);
  assign rstPull  = (state == S_RST);
  assign selN     = !(state inside {S_RST, S_CLEAR, S_CHK0, S_IMG});
  assign fetching = state inside {S_RST, S_CLEAR, S_CHK0, S_PRE, S_IMG};
  assign rdReq    = fetching && !bufFull && (fetchCnt != IMG_N);
  assign rdAddr   = ADDR_W'(fetchCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      tmr      <= '0;
      fetchCnt <= '0;
      sentCnt  <= '0;
      dumLeft  <= '0;
      bufData  <= '0;
      bufFull  <= 1'b0;
      doneMeta <= 1'b0;
      doneSync <= 1'b0;
      success  <= 1'b0;
      failure  <= 1'b0;
      errKind  <= ERR_NONE;
    end else begin
      doneMeta <= doneIn;
      doneSync <= doneMeta;

      if (rdReq && rdValid) begin
        bufData  <= rdData;
        bufFull  <= 1'b1;
        fetchCnt <= fetchCnt + 1'b1;
      end

      if (dpTake) begin
        if (state == S_IMG) begin
          bufFull <= 1'b0;
          sentCnt <= sentCnt + 1'b1;
        end else begin
          dumLeft <= dumLeft - 1'b1;
        end
      end

      unique case (state)
        S_IDLE: begin
          if (start) begin
            state    <= S_RST;
            tmr      <= TMR_W'(RST_CYCLES - 1);
            success  <= 1'b0;
            failure  <= 1'b0;
            errKind  <= ERR_NONE;
            fetchCnt <= '0;
            sentCnt  <= '0;
            bufFull  <= 1'b0;
          end
        end
        S_RST: begin
          if (tmr == '0) begin
            state <= S_CLEAR;
            tmr   <= TMR_W'(CLEAR_CYCLES - 1);
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_CLEAR: begin
          if (tmr == '0) state <= S_CHK0;
          else           tmr   <= tmr - 1'b1;
        end
        S_CHK0: begin
          if (doneSync) begin
            state   <= S_IDLE;
            failure <= 1'b1;
            errKind <= ERR_EARLY_DONE;
          end else begin
            state   <= S_PRE;
            dumLeft <= DUM_W'(PRE_BYTES);
          end
        end
        S_PRE: begin
          if (dumLeft == '0 && !dpBusy) state <= S_IMG;
        end
        S_IMG: begin
          if (!dpBusy && sentCnt != '0) begin
            if (sentCnt == IMG_N) begin
              state   <= S_POST;
              dumLeft <= DUM_W'(POST_BYTES);
            end else begin
              state   <= S_IDLE;
              failure <= 1'b1;
              errKind <= ERR_UNDERRUN;
            end
          end
        end
        S_POST: begin
          if (dumLeft == '0 && !dpBusy) state <= S_CHK1;
        end
        S_CHK1: begin
          if (doneSync) begin
            state   <= S_ACT;
            dumLeft <= DUM_W'(ACT_BYTES);
          end else begin
            state   <= S_IDLE;
            failure <= 1'b1;
            errKind <= ERR_NO_DONE;
          end
        end
        S_ACT: begin
          if (dumLeft == '0 && !dpBusy) begin
            state   <= S_IDLE;
            success <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfgSeqTop.sv
module cfgSeqTop
  import cfgSeqPkg::*;
#(
  parameter int HALF_DIV     = 8,
  parameter int RST_CYCLES   = 40,
  parameter int CLEAR_CYCLES = 240000,
  parameter int IMAGE_BYTES  = 135100,
  parameter int ADDR_W       = 18,
  parameter int POST_BYTES   = 13,
  parameter int ACT_BYTES    = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              success,
  output logic              failure,
  output logic [1:0]        errKind,
  output logic              cfgRstPull,
  output logic              cfgSelN,
  output logic              cfgSck,
  output logic              cfgMosi,
  input  logic              cfgDone,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdValid,
  input  logic [7:0]        rdData
);

  dpCmd_t            dpCmd;
  logic [BYTE_W-1:0] dpByte;
  logic              dpTake;
  logic              dpBusy;
  errKind_t          errState;

  cfgSeqCtl #(
    .RST_CYCLES  (RST_CYCLES),
    .CLEAR_CYCLES(CLEAR_CYCLES),
    .IMAGE_BYTES (IMAGE_BYTES),
    .ADDR_W      (ADDR_W),
    .PRE_BYTES   (1),
    .POST_BYTES  (POST_BYTES),
    .ACT_BYTES   (ACT_BYTES)
  ) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .doneIn (cfgDone),
    .dpTake (dpTake),
    .dpBusy (dpBusy),
    .rdValid(rdValid),
    .rdData (rdData),
    .dpCmd  (dpCmd),
    .dpByte (dpByte),
    .rdReq  (rdReq),
    .rdAddr (rdAddr),
    .busy   (busy),
    .success(success),
    .failure(failure),
    .errKind(errState),
    .selN   (cfgSelN),
    .rstPull(cfgRstPull)
  );

  cfgSerDp #(
    .HALF_DIV(HALF_DIV)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (dpCmd),
    .nextByte(dpByte),
    .take    (dpTake),
    .busy    (dpBusy),
    .sck     (cfgSck),
    .mosi    (cfgMosi)
  );

  assign errKind = errState;

endmodule

// File: rtl/cfgSeqChk.sv
module cfgSeqChk #(
  parameter int RST_CYCLES = 40
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic success,
  input logic failure,
  input logic cfgRstPull,
  input logic cfgSelN,
  input logic cfgSck,
  input logic cfgMosi,
  input logic rdReq,
  input logic rdValid,
  input logic [17:0] rdAddrLo
);

  int lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             lowCnt <= 0;
    else if (!cfgRstPull)                  lowCnt <= 0;
    else if (lowCnt < 32'h7FFF_FFFF)       lowCnt <= lowCnt + 1;
  end

  p_idle_lines_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (cfgSelN && cfgSck && !cfgRstPull && !rdReq));

  p_rst_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cfgRstPull) |-> (lowCnt >= RST_CYCLES));

  p_sel_low_in_rst_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgRstPull |-> (!cfgSelN && cfgSck));

  p_mosi_on_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgMosi) |-> $fell(cfgSck));

  p_sel_sck_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgSelN) |-> (cfgSck && $past(cfgSck)));

  p_status_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(success && failure));

  p_no_rerun_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cfgRstPull) |=> !cfgRstPull);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid && busy) |=> ((rdReq && $stable(rdAddrLo)) || !busy));

endmodule

bind cfgSeqTop cfgSeqChk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .success   (success),
  .failure   (failure),
  .cfgRstPull(cfgRstPull),
  .cfgSelN   (cfgSelN),
  .cfgSck    (cfgSck),
  .cfgMosi   (cfgMosi),
  .rdReq     (rdReq),
  .rdValid   (rdValid),
  .rdAddrLo  (18'(rdAddr))
);

// File: tb/tb_cfgSeqTop.sv
`timescale 1ns/1ps
module tb_cfgSeqTop;

  localparam int HALF   = 2;
  localparam int RSTC   = 5;
  localparam int CLRC   = 30;
  localparam int IMG    = 20;
  localparam int AW     = 18;
  localparam int DUMTOT = 8 + 104 + 104;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busy, success, failure;
  logic [1:0] errKind;
  logic cfgRstPull, cfgSelN, cfgSck, cfgMosi, cfgDone;
  logic rdReq, rdValid;
  logic [AW-1:0] rdAddr;
  logic [7:0] rdData;

  always #2.5 clk = ~clk;

  cfgSeqTop #(
    .HALF_DIV(HALF), .RST_CYCLES(RSTC), .CLEAR_CYCLES(CLRC),
    .IMAGE_BYTES(IMG), .ADDR_W(AW), .POST_BYTES(13), .ACT_BYTES(13)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .success(success),
    .failure(failure), .errKind(errKind), .cfgRstPull(cfgRstPull),
    .cfgSelN(cfgSelN), .cfgSck(cfgSck), .cfgMosi(cfgMosi), .cfgDone(cfgDone),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData)
  );

  int total = 0;
  int bad = 0;

  // stimulus knobs (driven by tasks only)
  logic forceDone = 1'b0;
  logic doneNormal = 1'b1;
  int   memLat = 2;
  int   stallAt = 1 << 30;

  function automatic logic [7:0] imgByte(input int a);
    return 8'((a * 37 + 11) & 8'hFF);
  endfunction

  // ---------------- port monitor (negedge) ----------------
  int dumBits = 0, dumNz = 0, imgBytes = 0, badBytes = 0, gapErr = 0;
  int rstPulses = 0, lowLen = 0, lastLowLen = 0, selAtRel = 1;
  int sinceRel = 0, firstEdge = 0, sinceRise = 0, protoErr = 0;
  int bitc = 0, idx = 0, base = 0;
  logic armEdge = 1'b0, lastRiseHigh = 1'b1, sckPrev = 1'b1, pullPrev = 1'b0;
  logic cfgOk = 1'b0;
  logic [7:0] shv = '0;

  assign cfgDone = forceDone | cfgOk;

  always @(negedge clk) begin
    if (cfgRstPull) lowLen++;
    if (!cfgRstPull && pullPrev) begin
      lastLowLen = lowLen; lowLen = 0; rstPulses++;
      selAtRel = int'(cfgSelN); armEdge = 1'b1; sinceRel = 0; base = imgBytes;
    end else if (armEdge) sinceRel++;
    if (armEdge && !cfgSck && sckPrev) begin firstEdge = sinceRel; armEdge = 1'b0; end
    sinceRise++;
    if (cfgSck && !sckPrev) begin
      if (cfgSelN) begin
        dumBits++;
        if (cfgMosi) dumNz++;
        lastRiseHigh = 1'b1;
      end else begin
        if (lastRiseHigh) begin bitc = 0; idx = 0; end
        else if (sinceRise != 2 * HALF) gapErr++;
        shv = {shv[6:0], cfgMosi};
        bitc++;
        if (bitc == 8) begin
          if (shv != imgByte(idx)) badBytes++;
          bitc = 0; idx++; imgBytes++;
        end
        lastRiseHigh = 1'b0;
      end
      sinceRise = 0;
    end
    cfgOk = doneNormal && !cfgRstPull && ((imgBytes - base) >= IMG) && (rstPulses > 0);
    sckPrev = cfgSck; pullPrev = cfgRstPull;
  end

  // ---------------- image memory model (negedge) ----------------
  int waitCnt = 0;
  logic reqPrev = 1'b0;
  logic [AW-1:0] addrPrev = '0;
  always @(negedge clk) begin
    if (busy && reqPrev && !rdValid && (!rdReq || rdAddr != addrPrev)) protoErr++;
    if (rdReq && busy) begin
      if (!rdValid && waitCnt >= memLat && int'(rdAddr) < stallAt) begin
        rdValid <= 1'b1; rdData <= imgByte(int'(rdAddr)); waitCnt = 0;
      end else begin
        rdValid <= 1'b0;
        if (!rdValid) waitCnt++;
      end
    end else begin
      rdValid <= 1'b0; waitCnt = 0;
    end
    reqPrev = rdReq; addrPrev = rdAddr;
  end

  // ---------------- helpers ----------------
  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    tick(); start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (busy && n < 20000) begin tick(); n++; end
    check({req, " run ends"}, int'(busy), 0);
    tick();
  endtask

  task automatic checkIdleLines(input string req);
    check({req, " selN idle"}, int'(cfgSelN), 1);
    check({req, " sck idle"}, int'(cfgSck), 1);
    check({req, " reset released"}, int'(cfgRstPull), 0);
    check({req, " no request"}, int'(rdReq), 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic tResetState();
    check("R1 busy", int'(busy), 0);
    check("R1 success", int'(success), 0);
    check("R1 failure", int'(failure), 0);
    checkIdleLines("R1");
  endtask

  task automatic tNominal();
    int d0 = dumBits, i0 = imgBytes, p0 = rstPulses;
    forceDone = 1'b0; doneNormal = 1'b1; memLat = 2; stallAt = 1 << 30;
    pulseStart();
    tick();
    check("R2 busy after start", int'(busy), 1);
    check("R2 select low with reset", int'(cfgSelN), 0);
    waitIdle("R8");
    check("R2 reset pulses", rstPulses - p0, 1);
    check("R2 reset width", int'(lastLowLen >= RSTC), 1);
    check("R3 select low at release", selAtRel, 0);
    check("R3 clear wait", int'(firstEdge >= CLRC), 1);
    check("R4 R7 R8 dummy clocks", dumBits - d0, DUMTOT);
    check("R4 dummy data zero", dumNz, 0);
    check("R5 image bytes", imgBytes - i0, IMG);
    check("R5 byte values", badBytes, 0);
    check("R5 R6 contiguous spacing", gapErr, 0);
    check("R8 success", int'(success), 1);
    check("R8 failure", int'(failure), 0);
    check("R8 errKind", int'(errKind), 0);
    checkIdleLines("R11");
    repeat (5) tick();
    check("R11 success held", int'(success), 1);
  endtask

  task automatic tEarlyDone();
    int d0 = dumBits, i0 = imgBytes;
    forceDone = 1'b1;
    pulseStart();
    waitIdle("R3");
    check("R3 failure", int'(failure), 1);
    check("R3 errKind early done", int'(errKind), 1);
    check("R3 no clocks", dumBits - d0 + imgBytes - i0, 0);
    check("R8 no success", int'(success), 0);
    checkIdleLines("R11");
    forceDone = 1'b0;
  endtask

  task automatic tNoDone();
    int d0 = dumBits, i0 = imgBytes;
    doneNormal = 1'b0;
    pulseStart();
    waitIdle("R7");
    check("R7 failure", int'(failure), 1);
    check("R7 errKind no done", int'(errKind), 2);
    check("R7 dummy clocks", dumBits - d0, 8 + 104);
    check("R7 image bytes", imgBytes - i0, IMG);
    doneNormal = 1'b1;
  endtask

  task automatic tUnderrun();
    int d0 = dumBits, i0 = imgBytes, b0 = badBytes;
    stallAt = 5;
    pulseStart();
    waitIdle("R9");
    check("R9 failure", int'(failure), 1);
    check("R9 errKind underrun", int'(errKind), 3);
    check("R9 bytes before stop", imgBytes - i0, 5);
    check("R9 no bad data", badBytes - b0, 0);
    check("R9 dummy only pre", dumBits - d0, 8);
    check("R9 clock parked", int'(cfgSck), 1);
    stallAt = 1 << 30;
  endtask

  task automatic tStartWhileBusy();
    int d0 = dumBits, i0 = imgBytes, p0 = rstPulses, pe0 = protoErr;
    memLat = 6;
    pulseStart();
    repeat (3) tick();
    pulseStart();
    repeat (CLRC + 200) tick();
    pulseStart();
    waitIdle("R10");
    check("R10 single reset pulse", rstPulses - p0, 1);
    check("R10 image intact", imgBytes - i0, IMG);
    check("R10 dummy intact", dumBits - d0, DUMTOT);
    check("R10 success", int'(success), 1);
    check("R12 request held", protoErr - pe0, 0);
    memLat = 2;
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (4) tick();
    rstN = 1'b1;
    tick();
    tResetState();
    tNominal();
    tEarlyDone();
    tNoDone();
    tUnderrun();
    tStartWhileBusy();
    tNominal();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule